// File: doc/BRIEF.md
# Codec-Side Serial Link Input Frame Serializer

This block sits on the codec end of a serial audio link and produces the frame that travels back toward the link controller. The controller marks each frame with a rising edge on a frame-sync line that changes with the rising edge of the bit clock. The block samples that line on falling edges. When it sees the line go from low to high, it takes one parallel snapshot of the outgoing frame contents. Starting on the next rising edge, it shifts out one bit per rising edge: a 16-bit tag slot, then twelve 20-bit data slots, each slot most significant bit first.

The snapshot is taken through a valid/ready handshake. Upstream logic drives `in_valid` together with the codec-ready flag, twelve per-slot valid flags and twelve 20-bit payload words. The block raises `in_ready` for exactly one bit-clock cycle per detected frame start, and the transfer happens on the rising edge where both signals are high. Upstream must hold the presented words steady while `in_valid` is high. Holding them steady until `in_ready` arrives is enough, since the block captures nothing at any other time. If `in_valid` is low at the capture point, the block does not stall. It sends that frame with every slot marked invalid and all payload bits zero, and still reports the codec-ready flag. The block cannot delay the frame, so it applies no back-pressure beyond the timing of `in_ready`.

Top module: `acl_in_serializer`

## Requirements
- R1: While reset is asserted, and after reset until the first frame-sync rise is recognised, `ser_out` is 0 and `in_ready` is 0.
- R2: A frame-sync rise is recognised on the first falling edge of `bit_clk` that samples `frame_sync` high after a falling-edge sample of low. The codec-ready bit appears on `ser_out` from the next rising edge.
- R3: The tag slot is 16 bits. Its bits in sending order are: codec ready; then the valid flags of slots 1 to 12 (slot k's flag is `slot_valid[k-1]`); then three zero bits.
- R4: After the tag, slots 1 to 12 follow in ascending order. Each sends 20 bits, most significant bit first. Slot k's word is `slot_data[(k-1)*20 +: 20]`. A frame is 256 bits, one per rising edge.
- R5: Every bit of a slot whose valid flag is 0 is sent as 0.
- R6: Flags and payload are captured only at frame start. Changing the inputs during a frame leaves the frame in flight unchanged.
- R7: A frame-sync rise recognised in the middle of a frame abandons that frame and starts a new one with a fresh capture.
- R8: After the 256th bit of a frame, `ser_out` stays 0 until the next recognised frame-sync rise.
- R9: `in_ready` is high for exactly one rising edge per recognised frame start. If `in_valid` is low at that edge, all slot valid bits and payload bits of the frame are 0, and the codec-ready bit is still sent.
- R10: Holding `frame_sync` high with no new low-to-high transition does not start another frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; outputs change on its rising edge, frame-sync sampled on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | Frame marker from the controller; a low-to-high transition starts a frame |
| codec_ready | input | 1 | Codec-ready flag placed in the first tag bit |
| in_valid | input | 1 | Upstream has a frame snapshot ready |
| in_ready | output | 1 | Snapshot taken at the next rising edge |
| slot_valid | input | 12 | Per-slot valid flags, bit k-1 for slot k |
| slot_data | input | 240 | Twelve 20-bit payload words, slot k at bits (k-1)*20 upward |
| ser_out | output | 1 | Serial frame output toward the controller |

## Verification
On every cycle, the assertions check the following: the single-cycle width of the capture window; that the first bit after recognition equals the codec-ready flag; that the sequencer restarts at the top of the tag on every frame start; that tag padding and invalid slots send zeros; and that the line is low while no frame is active. The bench scenarios alone cover the rest. They confirm the complete bit order of tag and payload, and the immunity of a frame to input changes after capture. They also cover a mid-frame restart, a capture with `in_valid` low, and a frame-sync held high well past the frame's end.

// File: rtl/acl_in_pkg.sv
package acl_in_pkg;
  localparam int unsigned DEF_SLOTS  = 12;
  localparam int unsigned DEF_SLOT_W = 20;
  localparam int unsigned DEF_TAG_W  = 16;
endpackage

// File: rtl/acl_sync_detect.sv
module acl_sync_detect (
  input  logic bit_clk,
  input  logic rst_n,
  input  logic frame_sync,
  output logic frame_start
);
  logic smp_now;
  logic smp_prev;

  // frame-sync is launched on rising edges, so sample it half a period later
  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_now  <= 1'b0;
      smp_prev <= 1'b0;
    end else begin
      smp_now  <= frame_sync;
      smp_prev <= smp_now;
    end
  end

  assign frame_start = smp_now & ~smp_prev;

  // R9: the capture window covers one rising edge only
  assert_ready_pulse_R9: assert property (@(posedge bit_clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
endmodule

// File: rtl/acl_frame_latch.sv
module acl_frame_latch #(
  parameter int unsigned N_SLOTS = acl_in_pkg::DEF_SLOTS,
  parameter int unsigned SLOT_W  = acl_in_pkg::DEF_SLOT_W
) (
  input  logic                        bit_clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic                        in_valid,
  input  logic                        codec_ready,
  input  logic [N_SLOTS-1:0]          slot_valid,
  input  logic [N_SLOTS*SLOT_W-1:0]   slot_data,
  output logic                        lat_ready,
  output logic [N_SLOTS-1:0]          lat_valid,
  output logic [N_SLOTS*SLOT_W-1:0]   lat_data
);
  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_ready <= 1'b0;
      lat_valid <= '0;
    end else if (load) begin
      lat_ready <= codec_ready;
      lat_valid <= in_valid ? slot_valid : '0;
    end
  end

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_word
    always_ff @(posedge bit_clk or negedge rst_n) begin
      if (!rst_n)
        lat_data[g*SLOT_W +: SLOT_W] <= '0;
      else if (load)
        lat_data[g*SLOT_W +: SLOT_W] <= (in_valid && slot_valid[g]) ?
                                        slot_data[g*SLOT_W +: SLOT_W] : '0;
    end
  end
endmodule

// File: rtl/acl_bit_seq.sv
module acl_bit_seq #(
  parameter int unsigned N_SLOTS = acl_in_pkg::DEF_SLOTS,
  parameter int unsigned SLOT_W  = acl_in_pkg::DEF_SLOT_W,
  parameter int unsigned TAG_W   = acl_in_pkg::DEF_TAG_W,
  localparam int unsigned SIX_W  = $clog2(N_SLOTS + 1),
  localparam int unsigned POS_W  = $clog2((TAG_W > SLOT_W) ? TAG_W : SLOT_W)
) (
  input  logic             bit_clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [SIX_W-1:0] slot,
  output logic [POS_W-1:0] pos
);
  // state names the next bit to send; the top tag bit goes out at start
  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      slot <= '0;
      pos  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      slot <= '0;
      pos  <= POS_W'(TAG_W - 2);
    end else if (busy) begin
      if (pos == '0) begin
        if (slot == SIX_W'(N_SLOTS)) begin
          busy <= 1'b0;
          slot <= '0;
        end else begin
          slot <= slot + 1'b1;
          pos  <= POS_W'(SLOT_W - 1);
        end
      end else begin
        pos <= pos - 1'b1;
      end
    end
  end
endmodule

// File: rtl/acl_bit_mux.sv
module acl_bit_mux #(
  parameter int unsigned N_SLOTS = acl_in_pkg::DEF_SLOTS,
  parameter int unsigned SLOT_W  = acl_in_pkg::DEF_SLOT_W,
  parameter int unsigned TAG_W   = acl_in_pkg::DEF_TAG_W,
  localparam int unsigned SIX_W  = $clog2(N_SLOTS + 1),
  localparam int unsigned POS_W  = $clog2((TAG_W > SLOT_W) ? TAG_W : SLOT_W),
  localparam int unsigned TIX_W  = $clog2(TAG_W),
  localparam int unsigned WIX_W  = $clog2(SLOT_W)
) (
  input  logic                      lat_ready,
  input  logic [N_SLOTS-1:0]        lat_valid,
  input  logic [N_SLOTS*SLOT_W-1:0] lat_data,
  input  logic [SIX_W-1:0]          slot,
  input  logic [POS_W-1:0]          pos,
  output logic                      bit_o
);
  logic [TAG_W-1:0]  tag_word;
  logic [SLOT_W-1:0] words [N_SLOTS];

  assign tag_word[TAG_W-1] = lat_ready;
  for (genvar g = 0; g < N_SLOTS; g++) begin : g_tag
    assign tag_word[TAG_W-2-g] = lat_valid[g];
    assign words[g]            = lat_data[g*SLOT_W +: SLOT_W];
  end
  if (TAG_W - 1 > N_SLOTS) begin : g_pad
    assign tag_word[TAG_W-2-N_SLOTS:0] = '0;
  end

  always_comb begin
    bit_o = 1'b0;
    if (slot == '0) begin
      bit_o = tag_word[pos[TIX_W-1:0]];
    end else begin
      for (int i = 0; i < N_SLOTS; i++)
        if (slot == SIX_W'(i + 1)) bit_o = words[i][pos[WIX_W-1:0]];
    end
  end
endmodule

// File: rtl/acl_in_serializer.sv
module acl_in_serializer #(
  parameter int unsigned N_SLOTS = acl_in_pkg::DEF_SLOTS,
  parameter int unsigned SLOT_W  = acl_in_pkg::DEF_SLOT_W,
  parameter int unsigned TAG_W   = acl_in_pkg::DEF_TAG_W,
  localparam int unsigned SIX_W  = $clog2(N_SLOTS + 1),
  localparam int unsigned POS_W  = $clog2((TAG_W > SLOT_W) ? TAG_W : SLOT_W),
  localparam int unsigned PAD_N  = TAG_W - 1 - N_SLOTS
) (
  input  logic                      bit_clk,
  input  logic                      rst_n,
  input  logic                      frame_sync,
  input  logic                      codec_ready,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [N_SLOTS-1:0]        slot_valid,
  input  logic [N_SLOTS*SLOT_W-1:0] slot_data,
  output logic                      ser_out
);
  logic                      frame_start;
  logic                      lat_ready;
  logic [N_SLOTS-1:0]        lat_valid;
  logic [N_SLOTS*SLOT_W-1:0] lat_data;
  logic                      busy;
  logic [SIX_W-1:0]          slot;
  logic [POS_W-1:0]          pos;
  logic                      mux_bit;
  logic                      ser_q;
  logic                      slot_on;

  acl_sync_detect u_sync (
    .bit_clk(bit_clk), .rst_n(rst_n), .frame_sync(frame_sync), .frame_start(frame_start)
  );

  acl_frame_latch #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) u_latch (
    .bit_clk(bit_clk), .rst_n(rst_n), .load(frame_start), .in_valid(in_valid),
    .codec_ready(codec_ready), .slot_valid(slot_valid), .slot_data(slot_data),
    .lat_ready(lat_ready), .lat_valid(lat_valid), .lat_data(lat_data)
  );

  acl_bit_seq #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W), .TAG_W(TAG_W)) u_seq (
    .bit_clk(bit_clk), .rst_n(rst_n), .start(frame_start),
    .busy(busy), .slot(slot), .pos(pos)
  );

  acl_bit_mux #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W), .TAG_W(TAG_W)) u_mux (
    .lat_ready(lat_ready), .lat_valid(lat_valid), .lat_data(lat_data),
    .slot(slot), .pos(pos), .bit_o(mux_bit)
  );

  // output flop: first bit comes straight from the input flag at capture
  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n)           ser_q <= 1'b0;
    else if (frame_start) ser_q <= codec_ready;
    else if (busy)        ser_q <= mux_bit;
    else                  ser_q <= 1'b0;
  end

  assign ser_out  = ser_q;
  assign in_ready = frame_start;

  always_comb begin
    slot_on = 1'b0;
    for (int i = 0; i < N_SLOTS; i++)
      if (slot == SIX_W'(i + 1)) slot_on = lat_valid[i];
  end

  assert_first_bit_R2: assert property (@(posedge bit_clk) disable iff (!rst_n)
    frame_start |=> (ser_out == $past(codec_ready)));

  assert_tag_pad_R3: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (busy && !frame_start && slot == '0 && pos < POS_W'(PAD_N)) |=> !ser_out);

  assert_invalid_zero_R5: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (busy && !frame_start && slot != '0 && !slot_on) |=> !ser_out);

  assert_restart_R7: assert property (@(posedge bit_clk) disable iff (!rst_n)
    frame_start |=> (busy && slot == '0 && pos == POS_W'(TAG_W - 2)));

  assert_idle_low_R8: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (!busy && !frame_start) |=> !ser_out);
endmodule

// File: tb/acl_in_serializer_tb.sv
module acl_in_serializer_tb;
  localparam int NS = 12;
  localparam int SW = 20;

  logic           bit_clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           frame_sync = 1'b0;
  logic           codec_ready = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [NS-1:0]  slot_valid = '0;
  logic [NS*SW-1:0] slot_data = '0;
  logic           ser_out;

  int    n_run = 0;
  int    n_fail = 0;
  bit    mon_en = 1'b0;
  bit    done = 1'b0;
  string idle_req = "R1";
  bit    exp_q[$];
  string req_q[$];

  always #5 bit_clk = ~bit_clk;

  acl_in_serializer u_dut (
    .bit_clk(bit_clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .codec_ready(codec_ready), .in_valid(in_valid), .in_ready(in_ready),
    .slot_valid(slot_valid), .slot_data(slot_data), .ser_out(ser_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: the controller side samples on falling edges
  always @(negedge bit_clk) begin
    if (mon_en && !done) begin
      if (exp_q.size() > 0) begin
        check(req_q.pop_front(), ser_out, exp_q.pop_front());
      end else begin
        check(idle_req, ser_out, 1'b0);
      end
    end
  end

  function automatic logic [SW-1:0] mk_word(input int seed, input int k);
    return SW'((seed * 32'h9E37 + k * 32'h1F3B5 + 32'h5A5A5) ^ (k << 7));
  endfunction

  // driver: raise frame-sync, present a snapshot, queue the expected bits
  task automatic send_frame(input logic rdy, input logic iv, input logic [NS-1:0] v,
                            input int seed, input string ovr, input int hold);
    logic [SW-1:0] w [NS];
    @(posedge bit_clk); #1;
    frame_sync  = 1'b1;
    codec_ready = rdy;
    in_valid    = iv;
    slot_valid  = v;
    for (int k = 0; k < NS; k++) begin
      w[k] = mk_word(seed, k);
      slot_data[k*SW +: SW] = w[k];
    end
    #5;  // just past the recognising falling edge
    check("R9", in_ready, 1'b1);
    exp_q.delete();
    req_q.delete();
    exp_q.push_back(rdy); req_q.push_back("R2");
    for (int k = 0; k < NS; k++) begin
      exp_q.push_back(iv & v[k]); req_q.push_back(iv ? "R3" : "R9");
    end
    for (int k = 0; k < 3; k++) begin
      exp_q.push_back(1'b0); req_q.push_back("R3");
    end
    for (int k = 0; k < NS; k++) begin
      for (int b = SW - 1; b >= 0; b--) begin
        if (iv && v[k]) begin
          exp_q.push_back(w[k][b]); req_q.push_back(ovr != "" ? ovr : "R4");
        end else begin
          exp_q.push_back(1'b0); req_q.push_back(iv ? "R5" : "R9");
        end
      end
    end
    @(posedge bit_clk); #6;
    check("R9", in_ready, 1'b0);
    repeat (hold) @(posedge bit_clk);
    #1 frame_sync = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #23;
    check("R1", ser_out, 1'b0);
    check("R1", in_ready, 1'b0);
    rst_n = 1'b1;
    mon_en = 1'b1;
    codec_ready = 1'b1;
    in_valid = 1'b1;
    slot_valid = '1;
    repeat (20) @(posedge bit_clk);
    check("R1", in_ready, 1'b0);
    idle_req = "R8";

    // all slots valid
    send_frame(1'b1, 1'b1, 12'hFFF, 3, "", 15);
    repeat (270) @(posedge bit_clk);
    // sparse valids, codec not ready
    send_frame(1'b0, 1'b1, 12'hA5C, 11, "", 15);
    repeat (270) @(posedge bit_clk);
    // no snapshot offered at capture
    send_frame(1'b1, 1'b0, 12'hFFF, 5, "", 15);
    repeat (270) @(posedge bit_clk);
    // R6: inputs move mid-frame, frame in flight must not change
    send_frame(1'b1, 1'b1, 12'h3F1, 7, "R6", 15);
    repeat (40) @(posedge bit_clk);
    #1;
    slot_valid = ~slot_valid;
    codec_ready = 1'b0;
    for (int k = 0; k < NS; k++) slot_data[k*SW +: SW] = ~slot_data[k*SW +: SW];
    repeat (220) @(posedge bit_clk);
    // R7: restart in the middle of a frame
    send_frame(1'b1, 1'b1, 12'hFFF, 21, "", 15);
    repeat (100) @(posedge bit_clk);
    send_frame(1'b1, 1'b1, 12'h9E7, 33, "R7", 15);
    repeat (270) @(posedge bit_clk);
    // R10: frame-sync held high far beyond the frame
    idle_req = "R10";
    send_frame(1'b0, 1'b1, 12'h0F0, 40, "", 320);
    repeat (20) @(posedge bit_clk);
    check("R10", in_ready, 1'b0);
    #1;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule